// File: doc/BRIEF.md
# Weak-Ordering Fence Controller

This block sits between a processor's in-order stream of memory requests and the memory system, and imposes weak ordering on that stream. Every request is either a plain data access (read or write) or a synchronization access. Data accesses pass straight through to the issue port whenever a tracking slot is free. A synchronization access is held at the head of the stream until every access issued before it has fully completed. Because the stream is in order, nothing behind a held synchronization access can overtake it.

Each issued access occupies one tracking slot, identified by a tag that goes out with the issue. The memory side returns completion events carrying that tag. A read or a synchronization access finishes on its first event. A write finishes only after its own memory response and one invalidation acknowledgement for each sharer the requester declared with the write. A counter of occupied slots opens the synchronization gate when it reads zero. It also pushes back on the request port when every slot is in use.

Top module: `wo_fence_ctrl`

## Requirements
- R1: A data request (req_sync low) is offered on the issue port in the same cycle it is presented, whatever the number of accesses in flight, as long as a slot is free. iss_valid then follows req_valid. The issue port carries req_addr, req_write and req_sync unchanged. When iss_ready is low, req_ready is low and stall stays low.
- R2: While a synchronization request (req_sync high) is presented and any issued access is still in flight, req_ready and iss_valid are low and stall is high.
- R3: A held synchronization request is accepted in the first cycle after the clock edge that retires the last access in flight. It is not accepted in the cycle in which that final completion event is presented.
- R4: A read, or an issued synchronization access, leaves flight after exactly one completion event (cmp_valid high with cmp_tag equal to its tag).
- R5: A write presented with req_acks = N stays in flight until N + 1 completion events with its tag have arrived: one memory response plus N invalidation acknowledgements.
- R6: Once DEPTH accesses are in flight, any presented request sees req_ready low and stall high. It is accepted in the cycle after a slot is released.
- R7: If a request is accepted in the same cycle as a completion event retires another access, the count of accesses in flight does not change.
- R8: The tag issued with an access (iss_tag) is the lowest-numbered slot that is not in flight.
- R9: After reset nothing is in flight: with iss_ready high and no request presented, req_ready is high, stall is low and iss_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronization access, 0 = data access |
| req_acks | input | ACKW | Invalidation acknowledgements expected for a write |
| iss_valid | output | 1 | Access offered to memory |
| iss_ready | input | 1 | Memory accepts the offered access |
| iss_addr | output | AW | Issued address |
| iss_write | output | 1 | Issued write flag |
| iss_sync | output | 1 | Issued synchronization flag |
| iss_tag | output | $clog2(DEPTH) | Tracking slot of the issued access |
| cmp_valid | input | 1 | Completion event (memory response or invalidation acknowledgement) |
| cmp_tag | input | $clog2(DEPTH) | Slot the completion event belongs to |
| stall | output | 1 | Request held by the fence or by full tracking |

## Verification
A slot that keeps too many or too few pending events shows up as a synchronization request that opens one or more cycles early or late against the expected release edge. It can also show as a later issue picking a different lowest free tag. A drifted in-flight counter shows up as a wrong stall: it either blocks a data request that should pass when slots are free, or it accepts one when all DEPTH slots are taken. It also blocks a synchronization request forever once the counter can no longer return to zero. All of these appear within one cycle of the completion or issue that exposes them. The bench therefore checks req_ready and stall in the exact cycles around each release.

// File: rtl/wo_fence_pkg.sv
package wo_fence_pkg;

    typedef enum logic [1:0] {
        OPK_READ  = 2'd0,
        OPK_WRITE = 2'd1,
        OPK_SYNC  = 2'd2
    } op_kind_e;

    // A synchronization access is tracked as one event, whatever its write flag.
    function automatic op_kind_e classify(input logic is_write, input logic is_sync);
        if (is_sync) begin
            return OPK_SYNC;
        end else if (is_write) begin
            return OPK_WRITE;
        end
        return OPK_READ;
    endfunction

endpackage

// File: rtl/wo_slot_pick.sv
module wo_slot_pick #(
    parameter int DEPTH = 4,
    parameter int TW    = 2
) (
    input  logic [DEPTH-1:0] busy_i,
    output logic [TW-1:0]    tag_o
);

    // Lowest free slot wins: scan from the top so the last hit is the lowest index.
    always_comb begin
        tag_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                tag_o = TW'(i);
            end
        end
    end

endmodule

// File: rtl/wo_ack_tracker.sv
module wo_ack_tracker #(
    parameter int DEPTH = 4,
    parameter int TW    = 2,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TW-1:0]    alloc_tag,
    input  logic [CW-1:0]    alloc_events,
    input  logic             cmp_valid,
    input  logic [TW-1:0]    cmp_tag,
    output logic [DEPTH-1:0] busy_o,
    output logic             rel_o
);

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] rem;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        rel_o = 1'b0;
        if (cmp_valid && (trk_q.rem[cmp_tag] != '0)) begin
            trk_d.rem[cmp_tag] = trk_q.rem[cmp_tag] - CW'(1);
            if (trk_q.rem[cmp_tag] == CW'(1)) begin
                rel_o = 1'b1;
            end
        end
        if (alloc_en) begin
            trk_d.rem[alloc_tag] = alloc_events;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_busy
        assign busy_o[g] = (trk_q.rem[g] != '0);
    end

    AST_ALLOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (trk_q.rem[alloc_tag] == '0)); // R8

    AST_ALLOC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> busy_o[$past(alloc_tag)]); // R5

endmodule

// File: rtl/wo_issue_gate.sv
module wo_issue_gate #(
    parameter int DEPTH = 4,
    parameter int CNTW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_sync,
    input  logic            iss_ready,
    input  logic            rel_i,
    output logic            allow_o,
    output logic            fire_o,
    output logic            stall_o,
    output logic [CNTW-1:0] count_o
);

    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    typedef struct packed {
        logic [CNTW-1:0] count;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  fence_hold;
    logic  full;

    always_comb begin
        fence_hold = req_sync && (gate_q.count != '0);
        full       = (gate_q.count == FULL_CNT);
        allow_o    = !fence_hold && !full;
        fire_o     = req_valid && iss_ready && allow_o;
        stall_o    = req_valid && !allow_o;

        gate_d = gate_q;
        unique case ({fire_o, rel_i})
            2'b10:   gate_d.count = gate_q.count + CNTW'(1);
            2'b01:   gate_d.count = gate_q.count - CNTW'(1);
            default: gate_d.count = gate_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign count_o = gate_q.count;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> (count_o != '0)); // R4

endmodule

// File: rtl/wo_fence_ctrl.sv
module wo_fence_ctrl
    import wo_fence_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int AW    = 32,
    parameter  int ACKW  = 3,
    localparam int TW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic            req_sync,
    input  logic [ACKW-1:0] req_acks,
    output logic            iss_valid,
    input  logic            iss_ready,
    output logic [AW-1:0]   iss_addr,
    output logic            iss_write,
    output logic            iss_sync,
    output logic [TW-1:0]   iss_tag,
    input  logic            cmp_valid,
    input  logic [TW-1:0]   cmp_tag,
    output logic            stall
);

    localparam int CW   = ACKW + 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    op_kind_e          kind;
    logic [CW-1:0]     events;
    logic [DEPTH-1:0]  busy;
    logic [TW-1:0]     free_tag;
    logic              allow;
    logic              fire;
    logic              rel;
    logic [CNTW-1:0]   count;

    always_comb begin
        kind = classify(req_write, req_sync);
        unique case (kind)
            OPK_WRITE: events = CW'(req_acks) + CW'(1);
            default:   events = CW'(1);
        endcase
    end

    wo_slot_pick #(
        .DEPTH (DEPTH),
        .TW    (TW)
    ) u_pick (
        .busy_i (busy),
        .tag_o  (free_tag)
    );

    wo_issue_gate #(
        .DEPTH (DEPTH),
        .CNTW  (CNTW)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_sync  (req_sync),
        .iss_ready (iss_ready),
        .rel_i     (rel),
        .allow_o   (allow),
        .fire_o    (fire),
        .stall_o   (stall),
        .count_o   (count)
    );

    wo_ack_tracker #(
        .DEPTH (DEPTH),
        .TW    (TW),
        .CW    (CW)
    ) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (fire),
        .alloc_tag    (free_tag),
        .alloc_events (events),
        .cmp_valid    (cmp_valid),
        .cmp_tag      (cmp_tag),
        .busy_o       (busy),
        .rel_o        (rel)
    );

    assign iss_valid = req_valid && allow;
    assign req_ready = iss_ready && allow;
    assign iss_addr  = req_addr;
    assign iss_write = req_write;
    assign iss_sync  = req_sync;
    assign iss_tag   = free_tag;

    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) == $countones(busy)); // R7

    AST_SYNC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sync) |-> (busy == '0)); // R2

    AST_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |-> !busy[iss_tag]); // R8

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !iss_valid); // R6

endmodule

// File: tb/wo_fence_ctrl_bench.sv
module wo_fence_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int AW         = 16;
    localparam int ACKW       = 3;
    localparam int TW         = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic            req_write = 1'b0;
    logic            req_sync = 1'b0;
    logic [ACKW-1:0] req_acks = '0;
    logic            iss_valid;
    logic            iss_ready = 1'b1;
    logic [AW-1:0]   iss_addr;
    logic            iss_write;
    logic            iss_sync;
    logic [TW-1:0]   iss_tag;
    logic            cmp_valid = 1'b0;
    logic [TW-1:0]   cmp_tag = '0;
    logic            stall;

    wo_fence_ctrl #(.DEPTH(DEPTH), .AW(AW), .ACKW(ACKW)) u_wo_fence_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_sync(req_sync), .req_acks(req_acks),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
        .iss_write(iss_write), .iss_sync(iss_sync), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .stall(stall)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic          sy;
        logic [TW-1:0] tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_err = 0;
    int   waited;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Monitor: compare every accepted issue against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected issue addr", int'(iss_addr), -1);
            end else begin
                mon_e = exp_q.pop_front();
                chk(iss_addr == mon_e.addr, "R1 issued addr", int'(iss_addr), int'(mon_e.addr));
                chk(iss_write == mon_e.wr && iss_sync == mon_e.sy, "R1 issued kind",
                    int'({iss_write, iss_sync}), int'({mon_e.wr, mon_e.sy}));
                chk(iss_tag == mon_e.tag, "R8 issued tag", int'(iss_tag), int'(mon_e.tag));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic present(input logic [AW-1:0] a, input logic wr, input logic sy,
                           input logic [ACKW-1:0] n);
        req_addr  = a;
        req_write = wr;
        req_sync  = sy;
        req_acks  = n;
        req_valid = 1'b1;
    endtask

    task automatic push_req(input logic [AW-1:0] a, input logic wr, input logic sy,
                            input logic [ACKW-1:0] n, input logic [TW-1:0] t);
        exp_t e;
        e.addr = a;
        e.wr   = wr;
        e.sy   = sy;
        e.tag  = t;
        exp_q.push_back(e);
        present(a, wr, sy, n);
    endtask

    task automatic send(input logic [AW-1:0] a, input logic wr, input logic sy,
                        input logic [ACKW-1:0] n, input logic [TW-1:0] t, output int w);
        push_req(a, wr, sy, n, t);
        w = 0;
        @(negedge clk);
        while (!req_ready) begin
            w++;
            @(negedge clk);
        end
        tick();
        req_valid = 1'b0;
    endtask

    task automatic complete(input logic [TW-1:0] t);
        cmp_valid = 1'b1;
        cmp_tag   = t;
        tick();
        cmp_valid = 1'b0;
    endtask

    task automatic expect_blocked(input string rq);
        @(negedge clk);
        chk(stall == 1'b1 && req_ready == 1'b0, rq, int'({stall, req_ready}), 2);
        tick();
    endtask

    task automatic expect_open(input string rq);
        @(negedge clk);
        chk(req_ready == 1'b1 && stall == 1'b0, rq, int'({stall, req_ready}), 1);
        tick();
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !stall && !iss_valid, "R9 reset state",
            int'({req_ready, stall, iss_valid}), 4);
        tick();

        // R1: data accesses flow while others are in flight
        send(16'h0100, 1'b0, 1'b0, 3'd0, 2'd0, waited);
        chk(waited == 0, "R1 read accepted at once", waited, 0);
        send(16'h0104, 1'b1, 1'b0, 3'd2, 2'd1, waited);
        chk(waited == 0, "R1 write accepted at once", waited, 0);
        send(16'h0108, 1'b0, 1'b0, 3'd0, 2'd2, waited);
        chk(waited == 0, "R1 read accepted with two in flight", waited, 0);

        // R2: sync held until all three retire; R5: write needs 3 events
        push_req(16'h01F0, 1'b0, 1'b1, 3'd0, 2'd0);
        expect_blocked("R2 sync held, three in flight");
        complete(2'd0);
        expect_blocked("R4 read retired, sync still held");
        complete(2'd1);
        expect_blocked("R5 write after one event still held");
        complete(2'd1);
        expect_blocked("R5 write after two events still held");
        complete(2'd1);
        expect_blocked("R2 read tag2 still in flight");
        cmp_valid = 1'b1;
        cmp_tag   = 2'd2;
        @(negedge clk);
        chk(req_ready == 1'b0, "R3 not accepted in final completion cycle", int'(req_ready), 0);
        tick();
        cmp_valid = 1'b0;
        expect_open("R3 sync accepted after last retire");

        // R4: issued sync retires after one event
        send(16'h0200, 1'b0, 1'b0, 3'd0, 2'd1, waited);
        chk(waited == 0, "R1 data behind issued sync", waited, 0);
        push_req(16'h02F0, 1'b0, 1'b1, 3'd0, 2'd0);
        expect_blocked("R2 second sync held");
        complete(2'd0);
        expect_blocked("R2 second sync held by read tag1");
        complete(2'd1);
        expect_open("R4 sync retired after single event");
        complete(2'd0);

        // R6: full tracking
        send(16'h0300, 1'b0, 1'b0, 3'd0, 2'd0, waited);
        send(16'h0301, 1'b1, 1'b0, 3'd0, 2'd1, waited);
        send(16'h0302, 1'b0, 1'b0, 3'd0, 2'd2, waited);
        send(16'h0303, 1'b0, 1'b0, 3'd0, 2'd3, waited);
        chk(waited == 0, "R6 fourth access accepted", waited, 0);
        push_req(16'h0310, 1'b0, 1'b0, 3'd0, 2'd2);
        expect_blocked("R6 full blocks data");
        cmp_valid = 1'b1;
        cmp_tag   = 2'd2;
        @(negedge clk);
        chk(req_ready == 1'b0 && stall == 1'b1, "R6 still full in release cycle",
            int'({stall, req_ready}), 2);
        tick();
        cmp_valid = 1'b0;
        expect_open("R6 accepted after slot release");

        // R7: issue and retire in the same cycle
        complete(2'd3);
        push_req(16'h0320, 1'b0, 1'b0, 3'd0, 2'd3);
        cmp_valid = 1'b1;
        cmp_tag   = 2'd0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 accept during completion", int'(req_ready), 1);
        tick();
        req_valid = 1'b0;
        cmp_valid = 1'b0;
        send(16'h0330, 1'b0, 1'b0, 3'd0, 2'd0, waited);
        chk(waited == 0, "R7 count unchanged, one slot left", waited, 0);
        present(16'h0340, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        chk(stall == 1'b1 && req_ready == 1'b0, "R7 full again after refill",
            int'({stall, req_ready}), 2);
        tick();
        req_valid = 1'b0;

        // Drain, then memory backpressure alone must not raise stall (R1)
        complete(2'd0);
        complete(2'd1);
        complete(2'd2);
        complete(2'd3);
        iss_ready = 1'b0;
        present(16'h0400, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        chk(req_ready == 1'b0 && stall == 1'b0 && iss_valid == 1'b1,
            "R1 memory backpressure without stall",
            int'({req_ready, stall, iss_valid}), 1);
        tick();
        req_valid = 1'b0;
        iss_ready = 1'b1;
        tick();
        chk(exp_q.size() == 0, "R8 every expected issue seen", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule